// File: doc/BRIEF.md
# Accumulator Arithmetic Shift-Round Unit

This unit takes a 40-bit signed accumulator value and shifts it right arithmetically by a count of 0 to 16. It shifts one bit per clock. It then rounds the result to the nearest multiple of 2^16 by adding half an LSB at bit 15, and forces the low 16 bits to zero. When saturation is enabled, a result outside the signed 32-bit range is clamped. The unit returns the new accumulator together with a set of status flags.

A single start strobe launches an operation. The count comes either from a 5-bit immediate or from the low nibble of a 16-bit register operand. When the operation completes, `done_o` pulses for one cycle and the accumulator and flag outputs update in the same cycle. Two of the flags are sticky: sticky overflow and saturation-limit. They accumulate across operations until reset.

Top module: `acc_sr_unit`

## Requirements
- R1: With `cnt_sel_i`=0 the shift count is `imm_i`. Any value above 16 is treated as 16.
- R2: With `cnt_sel_i`=1 the shift count is `reg_i[3:0]` (0 to 15), and `reg_i[15:4]` has no effect.
- R3: The shift is arithmetic. Each step moves bits 39:1 down into 38:0 and keeps bit 39, so a count of n produces the input divided by 2^n, rounded toward minus infinity.
- R4: After the shift, 0x00_0000_8000 is added modulo 2^40 and bits 15:0 of the result are cleared.
- R5: A start accepted while the unit is idle produces a one-cycle `done_o` exactly n+1 rising edges after the accepting edge, where n is the shift count. A start seen while busy is ignored. `acc_o` and the flags change only in the cycle in which `done_o` is high.
- R6: `carry_o` is the carry out of bit 39 of the unsigned rounding addition.
- R7: `ovf_o` is set when the signed rounding addition overflows 40 bits and cleared otherwise. `sovf_o` is set on such an overflow and is never cleared except by reset.
- R8: `ext_o` is set when bits 39:31 of the written result are not all equal, and cleared otherwise.
- R9: `zero_o` is set when the written result is zero. `neg_o` equals bit 39 of the written result.
- R10: With `sat_en_i`=1, a rounded value outside the signed 32-bit range is replaced by 0x00_7FFF_0000 when the true value is positive, or by 0xFF_8000_0000 when it is negative. `slim_o` is set on each such clamp and is otherwise left as it was.
- R11: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch an operation (accepted when idle) |
| cnt_sel_i | input | 1 | Count source: 0 immediate, 1 register |
| imm_i | input | 5 | Immediate shift count |
| reg_i | input | 16 | Register operand; low nibble is the count |
| sat_en_i | input | 1 | Enable 32-bit saturation |
| acc_i | input | 40 | Accumulator value to process |
| acc_o | output | 40 | Resulting accumulator |
| done_o | output | 1 | One-cycle completion pulse |
| ovf_o | output | 1 | 40-bit overflow on rounding |
| sovf_o | output | 1 | Sticky overflow |
| ext_o | output | 1 | Extension bits 39:31 in use |
| carry_o | output | 1 | Carry from rounding addition |
| zero_o | output | 1 | Result is zero |
| neg_o | output | 1 | Result sign |
| slim_o | output | 1 | Sticky saturation-limit |

## Verification
The bench sweeps every immediate count, including values above 16, against negative, boundary and mixed-bit accumulator patterns. A design that filled the top bit with zero would return large positive values for negative inputs. Register counts are tried with the upper bits of the operand set: a design that read more than four bits would shift too far and finish late. The largest positive value with no shift must raise overflow without carry, and an all-ones input must round to zero with carry. A value rounding to exactly 2^31 must clamp only when saturation is enabled. A design that sized the clamp on the truncated 40-bit sum would pick the wrong limit sign. Starts injected mid-operation, and the latency counted per count value, catch a loop that is off by one or that restarts.

// File: rtl/acc_sr_pkg.sv
package acc_sr_pkg;
  localparam int ACC_W     = 40;
  localparam int LOW_W     = 16;
  localparam int SAT_W     = 32;
  localparam int CNT_W     = 5;
  localparam int OPR_W     = 16;
  localparam int MAX_SHIFT = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_ROUND
  } state_e;
endpackage

// File: rtl/acc_sr_count.sv
module acc_sr_count
  import acc_sr_pkg::*;
#(
  parameter int CW  = CNT_W,
  parameter int RW  = OPR_W,
  parameter int MAX = MAX_SHIFT
) (
  input  logic          sel_reg_i,
  input  logic [CW-1:0] imm_i,
  input  logic [RW-1:0] reg_i,
  output logic [CW-1:0] cnt_o
);
  localparam int            RB   = CW - 1;
  localparam logic [CW-1:0] MAXV = CW'(MAX);

  logic [RW-RB-1:0] reg_unused;
  assign reg_unused = reg_i[RW-1:RB];

  always_comb begin
    if (sel_reg_i)         cnt_o = {1'b0, reg_i[RB-1:0]};
    else if (imm_i > MAXV) cnt_o = MAXV;
    else                   cnt_o = imm_i;
  end
endmodule

// File: rtl/acc_sr_shift.sv
module acc_sr_shift #(
  parameter int AW = 40,
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [AW-1:0] acc_i,
  input  logic [CW-1:0] cnt_i,
  output logic [AW-1:0] val_o,
  output logic [CW-1:0] cnt_o
);
  logic [AW-1:0] val_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      val_q <= acc_i;
      cnt_q <= cnt_i;
    end else if (step_i) begin
      val_q <= {val_q[AW-1], val_q[AW-1:1]};  // sign kept
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign val_o = val_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/acc_sr_round.sv
module acc_sr_round #(
  parameter int AW = 40,
  parameter int LW = 16,
  parameter int SW = 32
) (
  input  logic [AW-LW-1:0] hi_i,
  input  logic             rb_i,
  input  logic             sat_en_i,
  output logic [AW-1:0]    res_o,
  output logic             ovf_o,
  output logic             carry_o,
  output logic             sat_o,
  output logic             ext_o,
  output logic             zero_o,
  output logic             neg_o
);
  localparam int HW = AW - LW;
  localparam int FB = SW - 1 - LW;
  localparam logic [AW-1:0] POS_LIM =
    {{(AW-SW+1){1'b0}}, {(SW-1-LW){1'b1}}, {LW{1'b0}}};
  localparam logic [AW-1:0] NEG_LIM =
    {{(AW-SW+1){1'b1}}, {(SW-1){1'b0}}};

  logic [HW:0]   sum;
  logic [HW-FB:0] top;
  logic          fits;

  // rounding bit 15 added into the upper slice; true sign kept at bit HW
  assign sum     = {hi_i[HW-1], hi_i} + {{HW{1'b0}}, rb_i};
  assign carry_o = sum[HW] ^ hi_i[HW-1];
  assign ovf_o   = sum[HW] ^ sum[HW-1];
  assign top     = sum[HW:FB];
  assign fits    = (&top) | ~(|top);
  assign sat_o   = sat_en_i & ~fits;

  always_comb begin
    if (sat_o) res_o = sum[HW] ? NEG_LIM : POS_LIM;
    else       res_o = {sum[HW-1:0], {LW{1'b0}}};
  end

  assign ext_o  = ~((&res_o[AW-1:SW-1]) | ~(|res_o[AW-1:SW-1]));
  assign zero_o = (res_o == '0);
  assign neg_o  = res_o[AW-1];
endmodule

// File: rtl/acc_sr_unit.sv
module acc_sr_unit
  import acc_sr_pkg::*;
#(
  parameter int AW = ACC_W,
  parameter int LW = LOW_W,
  parameter int SW = SAT_W,
  parameter int CW = CNT_W,
  parameter int RW = OPR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          cnt_sel_i,
  input  logic [CW-1:0] imm_i,
  input  logic [RW-1:0] reg_i,
  input  logic          sat_en_i,
  input  logic [AW-1:0] acc_i,
  output logic [AW-1:0] acc_o,
  output logic          done_o,
  output logic          ovf_o,
  output logic          sovf_o,
  output logic          ext_o,
  output logic          carry_o,
  output logic          zero_o,
  output logic          neg_o,
  output logic          slim_o
);
  state_e        state_q;
  logic [CW-1:0] cnt_sel;
  logic [CW-1:0] sh_cnt;
  logic [AW-1:0] sh_val;
  logic          load, step, sat_q;
  logic [AW-1:0] r_res;
  logic          r_ovf, r_carry, r_sat, r_ext, r_zero, r_neg;

  assign load = (state_q == ST_IDLE) & start_i;
  assign step = (state_q == ST_SHIFT);

  acc_sr_count #(.CW(CW), .RW(RW), .MAX(MAX_SHIFT)) u_count (
    .sel_reg_i(cnt_sel_i),
    .imm_i    (imm_i),
    .reg_i    (reg_i),
    .cnt_o    (cnt_sel)
  );

  acc_sr_shift #(.AW(AW), .CW(CW)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .step_i(step),
    .acc_i (acc_i),
    .cnt_i (cnt_sel),
    .val_o (sh_val),
    .cnt_o (sh_cnt)
  );

  acc_sr_round #(.AW(AW), .LW(LW), .SW(SW)) u_round (
    .hi_i    (sh_val[AW-1:LW]),
    .rb_i    (sh_val[LW-1]),
    .sat_en_i(sat_q),
    .res_o   (r_res),
    .ovf_o   (r_ovf),
    .carry_o (r_carry),
    .sat_o   (r_sat),
    .ext_o   (r_ext),
    .zero_o  (r_zero),
    .neg_o   (r_neg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sat_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          sat_q   <= sat_en_i;
          state_q <= (cnt_sel == '0) ? ST_ROUND : ST_SHIFT;
        end
        ST_SHIFT: if (sh_cnt == CW'(1)) state_q <= ST_ROUND;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o   <= '0;
      done_o  <= 1'b0;
      ovf_o   <= 1'b0;
      sovf_o  <= 1'b0;
      ext_o   <= 1'b0;
      carry_o <= 1'b0;
      zero_o  <= 1'b0;
      neg_o   <= 1'b0;
      slim_o  <= 1'b0;
    end else begin
      done_o <= (state_q == ST_ROUND);
      if (state_q == ST_ROUND) begin
        acc_o   <= r_res;
        ovf_o   <= r_ovf;
        sovf_o  <= sovf_o | r_ovf;
        ext_o   <= r_ext;
        carry_o <= r_carry;
        zero_o  <= r_zero;
        neg_o   <= r_neg;
        slim_o  <= slim_o | r_sat;
      end
    end
  end
endmodule

// File: rtl/acc_sr_chk.sv
module acc_sr_chk #(
  parameter int AW = 40,
  parameter int LW = 16,
  parameter int SW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          done_o,
  input logic [AW-1:0] acc_o,
  input logic          sovf_o,
  input logic          slim_o,
  input logic          ext_o,
  input logic          zero_o,
  input logic          neg_o
);
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R5
  AST_ACC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(acc_o));  // R5
  AST_LOW_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> acc_o[LW-1:0] == '0);  // R4
  AST_STICKY_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sovf_o |=> sovf_o);  // R7
  AST_STICKY_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slim_o |=> slim_o);  // R10
  AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> zero_o == (acc_o == '0));  // R9
  AST_NEG_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> neg_o == acc_o[AW-1]);  // R9
  AST_EXT_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !ext_o |-> $countones(acc_o[AW-1:SW-1]) == 0 ||
                         $countones(acc_o[AW-1:SW-1]) == AW-SW+1);  // R8
endmodule

bind acc_sr_unit acc_sr_chk #(.AW(AW), .LW(LW), .SW(SW)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .done_o(done_o),
  .acc_o (acc_o),
  .sovf_o(sovf_o),
  .slim_o(slim_o),
  .ext_o (ext_o),
  .zero_o(zero_o),
  .neg_o (neg_o)
);

// File: tb/tb_acc_sr_unit.sv
module tb_acc_sr_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        cnt_sel_i = 1'b0;
  logic [4:0]  imm_i = '0;
  logic [15:0] reg_i = '0;
  logic        sat_en_i = 1'b0;
  logic [39:0] acc_i = '0;
  logic [39:0] acc_o;
  logic done_o, ovf_o, sovf_o, ext_o, carry_o, zero_o, neg_o, slim_o;

  int nchk = 0;
  int nerr = 0;
  bit exp_sovf = 0;
  bit exp_slim = 0;

  always #10 clk_i = ~clk_i;

  acc_sr_unit dut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [39:0] a, input int n, input bit sat,
                                output logic [39:0] r, output bit ovf, output bit cy,
                                output bit sh, output bit ext);
    longint s, t, rv;
    logic [40:0] u;
    longint mx40 = (longint'(1) <<< 39) - 1;
    longint mx32 = 64'sd2147483647;
    longint mn32 = -64'sd2147483648;
    s   = longint'({{24{a[39]}}, a}) >>> n;
    t   = s + 32768;
    ovf = t > mx40;
    u   = {1'b0, s[39:0]} + 41'h8000;
    cy  = u[40];
    if (sat && (t > mx32 || t < mn32)) begin
      sh = 1;
      r  = (t > 0) ? 40'h00_7FFF_0000 : 40'hFF_8000_0000;
    end else begin
      sh = 0;
      r  = {t[39:16], 16'h0000};
    end
    rv  = longint'({{24{r[39]}}, r});
    ext = rv > mx32 || rv < mn32;
  endfunction

  task automatic run_op(input bit sel, input logic [4:0] imm, input logic [15:0] rg,
                        input bit sat, input logic [39:0] a, input bit poke);
    int n, lat;
    logic [39:0] er, held;
    bit eo, ec, es, ee;
    string rq;
    n  = sel ? int'(rg[3:0]) : ((imm > 5'd16) ? 16 : int'(imm));
    rq = sel ? "R2" : "R1";
    model(a, n, sat, er, eo, ec, es, ee);
    exp_sovf |= eo;
    exp_slim |= es;
    @(negedge clk_i);
    start_i = 1; cnt_sel_i = sel; imm_i = imm; reg_i = rg; sat_en_i = sat; acc_i = a;
    @(negedge clk_i);
    start_i = 0;
    lat = 0;
    while (!done_o && lat < 40) begin
      if (poke && lat == 1) begin
        start_i = 1; acc_i = ~a; sat_en_i = ~sat; imm_i = 5'd0; cnt_sel_i = 0;
      end
      if (lat == 2) start_i = 0;
      @(negedge clk_i);
      lat++;
    end
    start_i = 0;
    chk(lat == n + 1, "R5 latency", 64'(lat), 64'(n + 1));
    chk(acc_o == er, {rq, " R3 R4 R10 result"}, 64'(acc_o), 64'(er));
    chk(carry_o == ec, "R6 carry", 64'(carry_o), 64'(ec));
    chk(ovf_o == eo && sovf_o == exp_sovf, "R7 ovf/sticky",
        {62'd0, ovf_o, sovf_o}, {62'd0, eo, exp_sovf});
    chk(ext_o == ee, "R8 ext", 64'(ext_o), 64'(ee));
    chk(zero_o == (er == 0) && neg_o == er[39], "R9 zero/neg",
        {62'd0, zero_o, neg_o}, {62'd0, er == 0, er[39]});
    chk(slim_o == exp_slim, "R10 sat-limit", 64'(slim_o), 64'(exp_slim));
    held = acc_o;
    @(negedge clk_i);
    chk(!done_o && acc_o == held, "R5 pulse/hold", {23'd0, done_o, acc_o}, {24'd0, held});
  endtask

  logic [39:0] pats [12];

  initial begin
    pats = '{40'h00_0000_0000, 40'h00_0000_0001, 40'h00_0000_8000, 40'h00_0001_7FFF,
             40'h7F_FFFF_FFFF, 40'h80_0000_0000, 40'hFF_FFFF_FFFF, 40'h00_7FFF_8000,
             40'hFF_8000_0000, 40'h12_3456_789A, 40'hA5_5A5A_A5A5, 40'h00_0000_7FFF};
    repeat (3) @(negedge clk_i);
    // R11: reset state
    chk({acc_o, done_o, ovf_o, sovf_o, ext_o, carry_o, zero_o, neg_o, slim_o} == '0,
        "R11 reset", {16'd0, acc_o, done_o, ovf_o, sovf_o, ext_o, carry_o, zero_o, neg_o, slim_o}, 64'd0);
    rst_ni = 1;
    // R1 R3 R4: immediate sweep, both saturation modes
    for (int p = 0; p < 12; p++)
      for (int k = 0; k <= 16; k++)
        for (int s = 0; s < 2; s++)
          run_op(0, 5'(k), 16'h0, s[0], pats[p], 0);
    // R1: counts above 16 clamp
    for (int k = 17; k < 32; k++)
      run_op(0, 5'(k), 16'h0, 0, pats[k % 12], 0);
    // R2: register low nibble only, upper bits set
    for (int k = 0; k < 16; k++)
      run_op(1, 5'd31, 16'hFFF0 | 16'(k), k[0], pats[(k + 5) % 12], 0);
    // R5: start while busy is ignored
    for (int k = 2; k <= 16; k += 7)
      run_op(0, 5'(k), 16'h0, 0, pats[10], 1);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule